// File: doc/BRIEF.md
# Legacy Speaker and System Control Ports

This block answers two byte-wide I/O ports of a PC-style system controller. The speaker port drives the gate input of an external interval-timer channel and a speaker-data enable, and reads those two bits back together with the live output of that timer channel and a refresh indicator. The refresh indicator is not tied to a clock. It inverts on every read of the speaker port, so software that polls it sees it change on each poll.

The system port holds a software-controlled processor soft-reset bit that goes straight to the reset output. A third address holds a 4-bit system control register. A read of any other address returns 0xFF, and a write to any other address is ignored. Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `legacy_ctl_ports`

## Requirements
- R1: After power-on reset (`rst_n` low), `tmr_gate`, `spk_en`, `cpu_reset`, the refresh indicator, the 4-bit control register and `io_rdata` are all 0.
- R2: A write to the speaker port (default 0x0061) loads `spk_en` from data bit 1 and `tmr_gate` from data bit 0. Both outputs change on the cycle after the write strobe.
- R3: A read of the speaker port returns `tmr_gate` in bit 0 and `spk_en` in bit 1. It returns the refresh indicator in bit 4 and the `tmr_out` level sampled at the strobe edge in bit 5. Bits 2, 3, 6 and 7 read as 0.
- R4: Each read of the speaker port inverts the refresh indicator exactly once, and the read returns the new value. No other access changes the indicator.
- R5: A write to the system port (default 0x0092) sets `cpu_reset` to data bit 0 on the next cycle. The other data bits are ignored.
- R6: A read of the system port returns `cpu_reset` in bit 0 and 0 in bits 7..1.
- R7: A write to the control register address (default 0x081C) stores data bits 3..0 only. A read returns them in bits 3..0, with bits 7..4 as 0.
- R8: A read of any other address returns 0xFF. A write to any other address changes no output and no stored bit.
- R9: `io_rdata` changes only on the cycle after a read strobe and holds its value in every other cycle. When a read and a write occur in the same cycle, the read returns the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | AW | Port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| tmr_out | input | 1 | Output level of timer channel 2 |
| tmr_gate | output | 1 | Gate of timer channel 2 |
| spk_en | output | 1 | Speaker-data enable |
| cpu_reset | output | 1 | Processor soft-reset request |

## Verification
Every result is due one clock after its strobe. The outputs written by a port, and the read data, both appear one cycle after the strobe edge. The bench drives each strobe for one cycle starting at a falling edge, and compares at the next falling edge, which lies half a period after the single register stage. The `tmr_out` level sampled in a read is the level the bench holds across that strobe edge. The bench's expected refresh bit is inverted once for each speaker-port read, before the returned value is compared.

// File: rtl/legacy_ctl_ports.sv
module legacy_ctl_ports #(
  parameter int AW       = 16,
  parameter int SPK_PORT = 'h0061,
  parameter int SYS_PORT = 'h0092,
  parameter int CFG_PORT = 'h081C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          tmr_out,
  output logic          tmr_gate,
  output logic          spk_en,
  output logic          cpu_reset
);
  localparam logic [AW-1:0] A_SPK = AW'(SPK_PORT);
  localparam logic [AW-1:0] A_SYS = AW'(SYS_PORT);
  localparam logic [AW-1:0] A_CFG = AW'(CFG_PORT);

  logic       gate_q, spk_q, rst_q, rfsh_q;
  logic [3:0] cfg_q;
  logic [7:0] rd_q, rd_mux;

  wire hit_spk = (io_addr == A_SPK);
  wire hit_sys = (io_addr == A_SYS);
  wire hit_cfg = (io_addr == A_CFG);

  always_comb begin
    if (hit_spk)      rd_mux = {2'b00, tmr_out, ~rfsh_q, 2'b00, spk_q, gate_q};
    else if (hit_sys) rd_mux = {7'd0, rst_q};
    else if (hit_cfg) rd_mux = {4'd0, cfg_q};
    else              rd_mux = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      spk_q  <= 1'b0;
      rst_q  <= 1'b0;
      rfsh_q <= 1'b0;
      cfg_q  <= 4'd0;
      rd_q   <= 8'd0;
    end else begin
      if (io_wr) begin
        if (hit_spk) begin
          gate_q <= io_wdata[0];
          spk_q  <= io_wdata[1];
        end
        if (hit_sys) rst_q <= io_wdata[0];
        if (hit_cfg) cfg_q <= io_wdata[3:0];
      end
      if (io_rd) begin
        rd_q <= rd_mux;
        if (hit_spk) rfsh_q <= ~rfsh_q;
      end
    end
  end

  assign io_rdata  = rd_q;
  assign tmr_gate  = gate_q;
  assign spk_en    = spk_q;
  assign cpu_reset = rst_q;
endmodule

// File: rtl/legacy_ctl_ports_chk.sv
module legacy_ctl_ports_chk #(
  parameter int AW       = 16,
  parameter int SPK_PORT = 'h0061,
  parameter int SYS_PORT = 'h0092,
  parameter int CFG_PORT = 'h081C
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    io_wdata,
  input logic [7:0]    io_rdata,
  input logic          tmr_out,
  input logic          tmr_gate,
  input logic          spk_en,
  input logic          cpu_reset
);
  wire s_spk = (io_addr == AW'(SPK_PORT));
  wire s_sys = (io_addr == AW'(SYS_PORT));
  wire s_cfg = (io_addr == AW'(CFG_PORT));

  // R2
  spk_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && s_spk) |=> (tmr_gate == $past(io_wdata[0]) && spk_en == $past(io_wdata[1])));

  // R3
  spk_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && s_spk) |=> (io_rdata[5] == $past(tmr_out) && io_rdata[3:2] == 2'b00 && io_rdata[7:6] == 2'b00));

  // R5
  sys_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && s_sys) |=> (cpu_reset == $past(io_wdata[0])));

  // R6
  sys_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && s_sys) |=> (io_rdata == {7'd0, $past(cpu_reset)}));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !s_spk && !s_sys && !s_cfg) |=> (io_rdata == 8'hFF));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  // R7
  cfg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && s_cfg) |=> (io_rdata[7:4] == 4'd0));
endmodule

bind legacy_ctl_ports legacy_ctl_ports_chk #(
  .AW(AW), .SPK_PORT(SPK_PORT), .SYS_PORT(SYS_PORT), .CFG_PORT(CFG_PORT)
) u_chk (.*);

// File: tb/legacy_ctl_ports_test.sv
module legacy_ctl_ports_test;
  localparam int AW = 16;
  localparam logic [15:0] P_SPK = 16'h0061, P_SYS = 16'h0092, P_CFG = 16'h081C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0, tmr_out = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic tmr_gate, spk_en, cpu_reset;

  int checks = 0, fails = 0;
  logic m_gate = 0, m_spk = 0, m_rst = 0, m_rf = 0;
  logic [3:0] m_cfg = 0;
  logic [7:0] last_rd = 0;

  always #2 clk = ~clk;

  legacy_ctl_ports uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check(tag, {29'd0, tmr_gate, spk_en, cpu_reset}, {29'd0, m_gate, m_spk, m_rst});
  endtask

  function automatic logic [7:0] exp_read(logic [AW-1:0] a, logic t);
    if (a == P_SPK) return {2'b00, t, m_rf, 2'b00, m_spk, m_gate};
    if (a == P_SYS) return {7'd0, m_rst};
    if (a == P_CFG) return {4'd0, m_cfg};
    return 8'hFF;
  endfunction

  task automatic do_write(logic [AW-1:0] a, logic [7:0] d, string tag);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == P_SPK) begin m_gate = d[0]; m_spk = d[1]; end
    if (a == P_SYS) m_rst = d[0];
    if (a == P_CFG) m_cfg = d[3:0];
    check_outs(tag);
    check({tag, " rdata hold R9"}, io_rdata, last_rd);
  endtask

  task automatic do_read(logic [AW-1:0] a, logic t, string tag);
    logic [7:0] e;
    io_addr = a; tmr_out = t; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    if (a == P_SPK) m_rf = ~m_rf;
    e = exp_read(a, t);
    last_rd = e;
    check(tag, io_rdata, e);
  endtask

  function automatic logic [AW-1:0] pick_addr(int k);
    logic [AW-1:0] r;
    case (k)
      0: return P_SPK;
      1: return P_SYS;
      2: return P_CFG;
      default: begin
        r = AW'($urandom);
        while (r == P_SPK || r == P_SYS || r == P_CFG) r = AW'($urandom);
        return r;
      end
    endcase
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {29'd0, tmr_gate, spk_en, cpu_reset}, 32'd0);
    check("R1 rdata", io_rdata, 8'h00);
    do_read(P_CFG, 1'b0, "R1 cfg reset R7");
    do_read(P_SPK, 1'b0, "R1 refresh reset R4");

    // R2, R3
    do_write(P_SPK, 8'hFF, "R2 spk write all ones");
    do_read(P_SPK, 1'b1, "R3 spk read bits");
    do_write(P_SPK, 8'h02, "R2 spk enable only");
    do_read(P_SPK, 1'b0, "R3 spk read tmr low");

    // R4 consecutive refresh toggles
    for (int i = 0; i < 4; i++) do_read(P_SPK, 1'b1, "R4 refresh toggle");
    do_read(P_SYS, 1'b0, "R4 non-spk read");
    do_read(P_SPK, 1'b0, "R4 refresh after other read");

    // R5, R6
    do_write(P_SYS, 8'hFE, "R5 sys bit0 clear others set");
    do_read(P_SYS, 1'b0, "R6 sys read low");
    do_write(P_SYS, 8'h01, "R5 sys reset assert");
    do_read(P_SYS, 1'b0, "R6 sys read high");

    // R7
    do_write(P_CFG, 8'hA5, "R7 cfg write");
    do_read(P_CFG, 1'b0, "R7 cfg read low nibble");

    // R8 unassigned
    do_write(16'h0060, 8'h00, "R8 unmapped write no effect");
    do_read(P_CFG, 1'b0, "R8 cfg kept");
    do_read(16'hFFFF, 1'b0, "R8 unmapped read");

    // R9 hold across idle cycles
    repeat (5) @(negedge clk);
    check("R9 rdata held idle", io_rdata, last_rd);

    // R9 read and write in the same cycle
    io_addr = P_CFG; io_wdata = 8'h03; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R9 read before write", io_rdata, {4'd0, m_cfg});
    m_cfg = 4'h3;
    last_rd = io_rdata;
    do_read(P_CFG, 1'b0, "R9 write took effect R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 4);
      logic [AW-1:0] a = pick_addr(k);
      if ($urandom_range(0, 1) == 1)
        do_write(a, 8'($urandom), "R2 R5 R7 R8 random write");
      else
        do_read(a, 1'($urandom), "R3 R4 R6 R7 R8 random read");
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        check("R9 random idle hold", io_rdata, last_rd);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule